// File: doc/BRIEF.md
# Display Pixel Register Readout Port

This block sits at the output of a composition pipeline. It gives a host or DMA engine a way to fetch composed pixels by polling a 32-bit read word, instead of having them go to the normal display FIFO. A routing input picks the path. When the register path is off, the incoming pixel stream passes straight through to the display-side outputs. When it is on, pixels are pulled into a small internal FIFO. They are then handed out one read at a time, with flags that show whether data is ready, whether the FIFO is empty, and whether the current line has been fully consumed.

The host paces the frame with write commands. One command bit starts a frame and another starts a line. Each accepted command is passed to the pipeline as a one-cycle request pulse. Programmed width and height fields set how many pixels make up a line and how many lines make up a frame. A one-shot option stops the path after one frame. A packed option turns each read into two 16-bit (5-6-5) pixels with no status bits.

Top module: `dslv_readout`

## Requirements
- R1: With `route_reg` low, `disp_valid` follows `in_valid`, `disp_data` equals `in_data`, `in_ready` equals `disp_ready`, and the register path takes in no pixel.
- R2: After reset the read word is 32'h0200_0000 (only the empty flag, bit 25, set), `req_frame` and `req_line` are low, and no pixel is accepted.
- R3: With packed mode off, the read word is {5'b0, eol, empty, valid, pixel}. Bits 23:0 hold the oldest buffered pixel (red 23:16, green 15:8, blue 7:0). Bit 24 is set when a pixel is buffered. A read strobe then removes that pixel, and pixels come out in arrival order.
- R4: A read while the FIFO is empty removes nothing and returns bit 24 clear, bit 25 set and bits 23:0 zero. The next pixel delivered is the one that would have come next anyway.
- R5: Once `cfg_width` pixels of a line have been read, bit 26 reads 1 and no further pixel is accepted. An accepted line-start clears bit 26.
- R6: A write with bit 31 set issues a frame-start and a write with bit 30 set issues a line-start. Each accepted command raises `req_frame` or `req_line` for the single cycle after the write. Both commands are ignored while a line is in progress. A write carrying both starts the frame and then its first line.
- R7: With packed mode on, a read returns {second, first} as two 5-6-5 pixels (R[7:3], G[7:2], B[7:3]; first in 15:0). A line with an odd count ends with a word whose upper half is zero. No status bits appear, and while no full pair or final single pixel is buffered the word is zero and a read removes nothing.
- R8: With one-shot on, the frame ends when the last pixel of line `cfg_height` is read. Line-start commands are then ignored until a frame-start.
- R9: With one-shot off, the line counter wraps after `cfg_height` lines, and the next line-start is accepted without a new frame-start.
- R10: At most DEPTH pixels are buffered (`in_ready` low when full), and exactly `cfg_width` pixels are accepted per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| route_reg | input | 1 | 1: register read path, 0: pass to display |
| packed_mode | input | 1 | Two 16-bit pixels per read, no status |
| oneshot | input | 1 | Stop after one frame |
| cfg_width | input | CNT_W | Pixels per line (at least 1) |
| cfg_height | input | CNT_W | Lines per frame |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Pixel accepted this cycle when high with in_valid |
| in_data | input | 3*CH_W | Source pixel, red in the top channel |
| disp_valid | output | 1 | Display-side pixel valid |
| disp_ready | input | 1 | Display side can take a pixel |
| disp_data | output | 3*CH_W | Display-side pixel |
| rd_en | input | 1 | Read strobe; removes what the word shows |
| rd_data | output | 32 | Read word |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word (bit 31 frame, bit 30 line) |
| req_frame | output | 1 | Frame-start request pulse |
| req_line | output | 1 | Line-start request pulse |

## Verification
Line widths from 1 to 5 are run in both word formats. Odd against even widths separates correct half-word padding from a lost or duplicated final pixel, and width 1 isolates the boundary where the first read is also the line's last. A line longer than the FIFO, left unread, shows whether the fill limit holds. A line-start written in the middle of that line shows whether commands during an active line are truly ignored, because the pixel sequence must continue unbroken. Reads issued right after a line-start, before any pixel has arrived, distinguish a safe empty read from an underflow. Running two lines past the programmed height, once with one-shot off and once with it on, separates wraparound from frame termination.

// File: rtl/dslv_pkg.sv
package dslv_pkg;

   // Read-word and command bit positions (decoded by software and DMA).
   localparam int VALID_BIT = 24;
   localparam int EMPTY_BIT = 25;
   localparam int EOL_BIT   = 26;
   localparam int CMD_FRAME = 31;
   localparam int CMD_LINE  = 30;
   localparam int WORD_W    = 32;
   localparam int RGB_W     = 24;

   typedef enum logic [1:0] {
      POP_NONE = 2'd0,
      POP_ONE  = 2'd1,
      POP_TWO  = 2'd2
   } pop_e;

endpackage

// File: rtl/dslv_fifo.sv
module dslv_fifo
   import dslv_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CW    = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  pop_e              pop,
   output logic [DATA_W-1:0] head0,
   output logic [DATA_W-1:0] head1,
   output logic [CW-1:0]     count,
   output logic              full
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [1:0]        pop_amt;

   assign pop_amt = pop;
   assign head0   = mem[rd_ptr];
   assign head1   = mem[rd_ptr + PTR_W'(1)];
   assign full    = (count == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         rd_ptr <= rd_ptr + PTR_W'(pop_amt);
         count  <= count + CW'(push) - CW'(pop_amt);
      end
   end

endmodule

// File: rtl/dslv_seq.sv
module dslv_seq
   import dslv_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_frame,
   input  logic             cmd_line,
   input  logic             oneshot,
   input  logic [CNT_W-1:0] width,
   input  logic [CNT_W-1:0] height,
   input  logic             push,
   input  pop_e             pop,
   output logic             frame_act,
   output logic             line_act,
   output logic             eol_flag,
   output logic             fetch_ok,
   output logic [CNT_W-1:0] remaining,
   output logic             req_frame,
   output logic             req_line
);

   logic [CNT_W-1:0] fetch_cnt, read_cnt, line_idx, line_nxt;
   logic [CNT_W:0]   read_sum;
   logic [1:0]       pop_amt;
   logic             frame_go, line_go, line_end;

   assign pop_amt   = pop;
   assign frame_go  = cmd_frame && !line_act;
   assign line_go   = cmd_line && !line_act && (frame_act || frame_go);
   assign read_sum  = {1'b0, read_cnt} + (CNT_W+1)'(pop_amt);
   assign line_end  = line_act && (pop_amt != 2'd0) && (read_sum == {1'b0, width});
   assign line_nxt  = line_idx + CNT_W'(1);
   assign fetch_ok  = line_act && (fetch_cnt < width);
   assign remaining = width - read_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_act <= 1'b0;
         line_act  <= 1'b0;
         eol_flag  <= 1'b0;
         fetch_cnt <= '0;
         read_cnt  <= '0;
         line_idx  <= '0;
         req_frame <= 1'b0;
         req_line  <= 1'b0;
      end else begin
         req_frame <= frame_go;
         req_line  <= line_go;
         if (frame_go) begin
            frame_act <= 1'b1;
            line_idx  <= '0;
         end
         if (line_go) begin
            line_act  <= 1'b1;
            eol_flag  <= 1'b0;
            fetch_cnt <= '0;
            read_cnt  <= '0;
         end else begin
            if (push) fetch_cnt <= fetch_cnt + CNT_W'(1);
            if (pop_amt != 2'd0) read_cnt <= read_sum[CNT_W-1:0];
            if (line_end) begin
               line_act <= 1'b0;
               eol_flag <= 1'b1;
               if (line_nxt == height) begin
                  line_idx <= '0;
                  if (oneshot) frame_act <= 1'b0;
               end else begin
                  line_idx <= line_nxt;
               end
            end
         end
      end
   end

endmodule

// File: rtl/dslv_fmt.sv
module dslv_fmt
   import dslv_pkg::*;
#(
   parameter int CH_W  = 8,
   parameter int CW    = 3,
   parameter int CNT_W = 12,
   localparam int PIX_W = 3 * CH_W
) (
   input  logic              packed_mode,
   input  logic              rd_en,
   input  logic              eol_flag,
   input  logic [PIX_W-1:0]  head0,
   input  logic [PIX_W-1:0]  head1,
   input  logic [CW-1:0]     count,
   input  logic [CNT_W-1:0]  remaining,
   output logic [WORD_W-1:0] word,
   output pop_e              pop
);

   logic [15:0] c0, c1;

   // Per-channel reduction to 5-6-5: blue (ch 0), green (ch 1), red (ch 2).
   for (genvar ch = 0; ch < 3; ch++) begin : g_ch
      localparam int KEEP = (ch == 1) ? 6 : 5;
      localparam int OLSB = (ch == 0) ? 0 : ((ch == 1) ? 5 : 11);
      localparam int IMSB = ch * CH_W + CH_W - 1;
      assign c0[OLSB +: KEEP] = head0[IMSB -: KEEP];
      assign c1[OLSB +: KEEP] = head1[IMSB -: KEEP];
   end

   logic have_one, have_pair, last_one;

   assign have_one  = (count != '0);
   assign have_pair = (count >= CW'(2)) && (remaining >= CNT_W'(2));
   assign last_one  = have_one && (remaining == CNT_W'(1));

   always_comb begin
      word = '0;
      pop  = POP_NONE;
      if (packed_mode) begin
         if (have_pair) begin
            word = {c1, c0};
            if (rd_en) pop = POP_TWO;
         end else if (last_one) begin
            word = {16'h0000, c0};
            if (rd_en) pop = POP_ONE;
         end
      end else begin
         word[EOL_BIT]   = eol_flag;
         word[EMPTY_BIT] = !have_one;
         word[VALID_BIT] = have_one;
         if (have_one) begin
            word[RGB_W-1:0] = RGB_W'(head0);
            if (rd_en) pop = POP_ONE;
         end
      end
   end

endmodule

// File: rtl/dslv_readout.sv
module dslv_readout
   import dslv_pkg::*;
#(
   parameter int CH_W  = 8,
   parameter int DEPTH = 4,
   parameter int CNT_W = 12,
   localparam int PIX_W = 3 * CH_W,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              route_reg,
   input  logic              packed_mode,
   input  logic              oneshot,
   input  logic [CNT_W-1:0]  cfg_width,
   input  logic [CNT_W-1:0]  cfg_height,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_data,
   output logic              disp_valid,
   input  logic              disp_ready,
   output logic [PIX_W-1:0]  disp_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              req_frame,
   output logic              req_line
);

   if (CH_W < 6 || CH_W > 8) begin : g_bad_ch
      $error("CH_W must lie in 6..8");
   end
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 2..16");
   end

   logic [PIX_W-1:0] head0, head1;
   logic [CW-1:0]    fifo_cnt;
   logic [CNT_W-1:0] remaining;
   logic             fifo_full, fetch_ok, push;
   logic             frame_act, line_act, eol_flag;
   pop_e             pop_sel;

   assign in_ready   = route_reg ? (fetch_ok && !fifo_full) : disp_ready;
   assign push       = route_reg && in_valid && fetch_ok && !fifo_full;
   assign disp_valid = !route_reg && in_valid;
   assign disp_data  = in_data;

   dslv_fifo #(.DATA_W(PIX_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (in_data),
      .pop   (pop_sel),
      .head0 (head0),
      .head1 (head1),
      .count (fifo_cnt),
      .full  (fifo_full)
   );

   dslv_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_frame (wr_en && wr_data[CMD_FRAME]),
      .cmd_line  (wr_en && wr_data[CMD_LINE]),
      .oneshot   (oneshot),
      .width     (cfg_width),
      .height    (cfg_height),
      .push      (push),
      .pop       (pop_sel),
      .frame_act (frame_act),
      .line_act  (line_act),
      .eol_flag  (eol_flag),
      .fetch_ok  (fetch_ok),
      .remaining (remaining),
      .req_frame (req_frame),
      .req_line  (req_line)
   );

   dslv_fmt #(.CH_W(CH_W), .CW(CW), .CNT_W(CNT_W)) u_fmt (
      .packed_mode (packed_mode),
      .rd_en       (rd_en),
      .eol_flag    (eol_flag),
      .head0       (head0),
      .head1       (head1),
      .count       (fifo_cnt),
      .remaining   (remaining),
      .word        (rd_data),
      .pop         (pop_sel)
   );

endmodule

// File: rtl/dslv_readout_chk.sv
module dslv_readout_chk #(
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          route_reg,
   input logic          packed_mode,
   input logic          in_valid,
   input logic          in_ready,
   input logic          rd_en,
   input logic [31:0]   rd_data,
   input logic          wr_en,
   input logic [31:0]   wr_data,
   input logic          req_frame,
   input logic          req_line,
   input logic [CW-1:0] fifo_cnt,
   input logic          frame_act,
   input logic          eol_flag
);

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(DEPTH));

   // R4
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && fifo_cnt == '0 && !(in_valid && in_ready)) |=> (fifo_cnt == '0));

   // R3
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !packed_mode |-> (rd_data[24] ^ rd_data[25]));

   // R5
   eol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_reg && eol_flag) |-> !in_ready);

   // R6
   line_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_line |-> $past(wr_en && wr_data[30]));

   // R6
   frame_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_frame |-> $past(wr_en && wr_data[31]));

   // R8
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_act && !(wr_en && wr_data[31])) |=> !req_line);

   // R1
   bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!route_reg && !rd_en) |=> $stable(fifo_cnt));

endmodule

bind dslv_readout dslv_readout_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .route_reg   (route_reg),
   .packed_mode (packed_mode),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .rd_en       (rd_en),
   .rd_data     (rd_data),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .req_frame   (req_frame),
   .req_line    (req_line),
   .fifo_cnt    (fifo_cnt),
   .frame_act   (frame_act),
   .eol_flag    (eol_flag)
);

// File: tb/tb_dslv_readout.sv
module tb_dslv_readout;

   localparam int DEPTH = 4;
   localparam int CNT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             route_reg = 1'b1, packed_mode = 1'b0, oneshot = 1'b0;
   logic [CNT_W-1:0] cfg_width = CNT_W'(1), cfg_height = CNT_W'(2);
   logic             in_valid = 1'b1, in_ready;
   logic [23:0]      in_data;
   logic             disp_valid, disp_ready = 1'b0;
   logic [23:0]      disp_data;
   logic             rd_en = 1'b0, wr_en = 1'b0;
   logic [31:0]      rd_data, wr_data = '0;
   logic             req_frame, req_line;

   int n_tests = 0, n_fail = 0;
   int k = 0, expi = 0;

   always #5 clk = ~clk;

   dslv_readout #(.CH_W(8), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (.*);

   function automatic logic [23:0] pix(int n);
      logic [7:0] b;
      b = n[7:0];
      return {8'(b * 8'd37 + 8'd5), 8'(b * 8'd11 + 8'd200), ~b};
   endfunction

   function automatic logic [15:0] p565(logic [23:0] p);
      return 16'((p[23:16] >> 3) * 2048 + (p[15:8] >> 2) * 32 + (p[7:0] >> 3));
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      bit fire;
      #1;
      fire = in_valid && in_ready;
      @(posedge clk);
      if (fire) k++;
      @(negedge clk);
      in_data = pix(k);
   endtask

   task automatic write_cmd(logic [31:0] w);
      wr_en = 1'b1; wr_data = w;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic read_one();
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic run_line(int w, bit pk, logic [31:0] cmd, bit fill_mid);
      int guard;
      cfg_width = CNT_W'(w);
      packed_mode = pk;
      write_cmd(cmd);
      chk(req_line == 1'b1, "R6 line req", 32'(req_line), 1);
      chk(req_frame == cmd[31], "R6 frame req", 32'(req_frame), 32'(cmd[31]));
      rd_en = 1'b1;
      if (pk) chk(rd_data == 32'h0, "R7 no word yet", rd_data, 0);
      else    chk(rd_data == 32'h0200_0000, "R4 empty read", rd_data, 32'h0200_0000);
      tick();
      rd_en = 1'b0;
      if (!pk) begin
         if (fill_mid) begin
            repeat (8) tick();
            chk(in_ready == 1'b0, "R10 full stall", 32'(in_ready), 0);
            chk(k - expi == DEPTH, "R10 buffered", 32'(k - expi), DEPTH);
         end
         for (int i = 0; i < w; i++) begin
            if (fill_mid && i == 2) begin
               write_cmd(32'h4000_0000);
               chk(req_line == 1'b0, "R6 mid-line ignored", 32'(req_line), 0);
            end
            guard = 0;
            while (!rd_data[24] && guard < 20) begin tick(); guard++; end
            chk(rd_data == {8'h01, pix(expi)}, "R3 pixel word", rd_data, {8'h01, pix(expi)});
            read_one();
            expi++;
         end
      end else begin
         repeat (DEPTH + 2) tick();
         for (int j = 0; j < (w + 1) / 2; j++) begin
            logic [31:0] e;
            bit two;
            two = (2 * j + 1 < w);
            e = {two ? p565(pix(expi + 1)) : 16'h0, p565(pix(expi))};
            if (j != 0) repeat (3) tick();
            chk(rd_data == e, "R7 packed word", rd_data, e);
            read_one();
            expi += two ? 2 : 1;
         end
         chk(rd_data == 32'h0, "R7 no status", rd_data, 0);
         packed_mode = 1'b0;
      end
      repeat (2) tick();
      chk(rd_data == 32'h0600_0000, "R5 end of line", rd_data, 32'h0600_0000);
      chk(in_ready == 1'b0 && k == expi, "R5 no fetch after eol", 32'(k), 32'(expi));
   endtask

   initial begin
      in_data = pix(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2
      chk(rd_data == 32'h0200_0000, "R2 reset word", rd_data, 32'h0200_0000);
      chk(!req_frame && !req_line, "R2 no requests", {req_frame, req_line}, 0);
      chk(in_ready == 1'b0, "R2 no accept", 32'(in_ready), 0);

      // R1 bypass
      route_reg = 1'b0;
      #1;
      chk(in_ready == 1'b0 && disp_valid == 1'b1, "R1 bypass stall", {in_ready, disp_valid}, 32'h1);
      chk(disp_data == in_data, "R1 bypass data", 32'(disp_data), 32'(in_data));
      disp_ready = 1'b1;
      #1;
      chk(in_ready == 1'b1, "R1 bypass ready", 32'(in_ready), 1);
      repeat (3) tick();
      chk(rd_data == 32'h0200_0000, "R1 register path idle", rd_data, 32'h0200_0000);
      disp_ready = 1'b0;
      route_reg = 1'b1;
      expi = k;

      // R6 frame-start alone
      write_cmd(32'h8000_0000);
      chk(req_frame == 1'b1 && req_line == 1'b0, "R6 frame only", {req_frame, req_line}, 32'h2);
      tick();
      chk(req_frame == 1'b0, "R6 single pulse", 32'(req_frame), 0);

      // R3/R5/R9 continuous frames, widths 1..5, two lines each
      for (int w = 1; w <= 5; w++) begin
         run_line(w, 1'b0, 32'h4000_0000, 1'b0);
         run_line(w, 1'b0, 32'h4000_0000, 1'b0); // R9 wraps past height
      end

      // R10 fill limit and mid-line command
      run_line(6, 1'b0, 32'h4000_0000, 1'b1);

      // R7 packed widths 1..5
      for (int w = 1; w <= 5; w++) run_line(w, 1'b1, 32'h4000_0000, 1'b0);

      // R8 one-shot
      oneshot = 1'b1;
      write_cmd(32'h8000_0000);
      run_line(3, 1'b0, 32'h4000_0000, 1'b0);
      run_line(3, 1'b0, 32'h4000_0000, 1'b0);
      write_cmd(32'h4000_0000);
      chk(req_line == 1'b0, "R8 line-start ignored", 32'(req_line), 0);
      repeat (3) tick();
      chk(rd_data == 32'h0600_0000 && in_ready == 1'b0, "R8 stopped", rd_data, 32'h0600_0000);
      run_line(3, 1'b0, 32'hC000_0000, 1'b0); // R6 frame then line
      oneshot = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule